// File: doc/BRIEF.md
# Register File with Hardware Call-Save Stack

This block holds a 64-entry, 16-bit register file. Two ports each carry an address, write data and a write enable, and each port also returns the read data for its address. A few entries have special roles. Entry 15 reflects an external 16-bit input bus. Entry 16 drives an external 16-bit output bus. Entry 57 holds a compare result that a set-less-than operation writes through its own strobe. Entry 63 is a constant zero.

Beside the register file sits a 16-deep save stack with 256-bit entries. A one-cycle save pulse copies entries 0 to 14 and the return-address register into the stack slot at the current depth, then increments the depth. A one-cycle load pulse first decrements the depth, then copies that slot back into entries 0 to 14 and the return address. Nested calls therefore keep their callee-safe values without any software spills.

Top module: `regfile_callstack`

## Requirements
- R1: After reset every register, the return address, the output bus, the stack depth and the error flag read zero.
- R2: Each port writes `wdataN` to entry `addrN` on a clock edge when `weN` is high. `rdataN` shows the current content of entry `addrN` combinationally.
- R3: When both ports write the same entry in one cycle, the value from port 2 is stored.
- R4: Reading entry 15 returns `in_port` in the same cycle. Writes to entry 15 are ignored.
- R5: `out_port` always equals the content of entry 16.
- R6: Entry 63 always reads zero. Writes to it are ignored.
- R7: `cmp_we` stores `{15'b0, cmp_bit}` into entry 57. This takes precedence over port writes to entry 57 in the same cycle.
- R8: A save pulse with the stack not full stores `{ret_addr, r14, ..., r0}` in the slot at the current depth. The return address goes in bits 255:240 and register i goes in bits 16i+15:16i. The depth then rises by one and no register changes.
- R9: A load pulse with the stack not empty lowers the depth by one. It then reloads entries 0 to 14 and the return address from that slot. Entries 15 to 62 are left unchanged.
- R10: A load overrides port writes to entries 0 to 14 and any `ra_we` write in the same cycle.
- R11: Nested saves and loads return values in last-in, first-out order.
- R12: A save at depth 16, a load at depth 0, or a save and a load in the same cycle raise `stk_err` for one cycle. The depth, the registers and the stack are left unchanged.
- R13: `ra_we` loads `ra_wdata` into the return-address register, which is visible on `ret_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr1 | input | 6 | Port 1 register index |
| wdata1 | input | 16 | Port 1 write data |
| we1 | input | 1 | Port 1 write enable |
| rdata1 | output | 16 | Port 1 read data |
| addr2 | input | 6 | Port 2 register index |
| wdata2 | input | 16 | Port 2 write data |
| we2 | input | 1 | Port 2 write enable |
| rdata2 | output | 16 | Port 2 read data |
| cmp_we | input | 1 | Compare-result write strobe for entry 57 |
| cmp_bit | input | 1 | Compare result |
| ra_we | input | 1 | Return-address write enable |
| ra_wdata | input | 16 | Return-address write data |
| ret_addr | output | 16 | Current return address |
| save | input | 1 | Push callee-safe set onto the stack |
| load | input | 1 | Pop callee-safe set from the stack |
| depth | output | 5 | Current stack depth |
| stk_err | output | 1 | One-cycle flag for a rejected save or load |
| in_port | input | 16 | External input bus, read as entry 15 |
| out_port | output | 16 | External output bus, driven by entry 16 |

## Verification
The hardest state to reach is a stack full of distinct frames. That is the only place where a rejected push could silently overwrite the top slot, or a wrong slot index could surface. The stimulus fills all 16 slots and stamps each frame with its own value in entry 0. It then attempts a seventeenth save with a new stamp, and pops to confirm that the sixteenth frame's stamp comes back. A separate two-level nest tests restore priority over same-cycle port and return-address writes. It also confirms that entries above 14 survive a pop.

// File: rtl/regfile_callstack.sv
module regfile_callstack #(
  parameter int DW        = 16,
  parameter int AW        = 6,
  parameter int SAVE_N    = 15,
  parameter int STK_DEPTH = 16,
  parameter int IN_IDX    = 15,
  parameter int OUT_IDX   = 16,
  parameter int CMP_IDX   = 57,
  parameter int ZERO_IDX  = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    addr1,
  input  logic [DW-1:0] wdata1,
  input  logic          we1,
  output logic [DW-1:0] rdata1,
  input  logic [5:0]    addr2,
  input  logic [DW-1:0] wdata2,
  input  logic          we2,
  output logic [DW-1:0] rdata2,
  input  logic          cmp_we,
  input  logic          cmp_bit,
  input  logic          ra_we,
  input  logic [DW-1:0] ra_wdata,
  output logic [DW-1:0] ret_addr,
  input  logic          save,
  input  logic          load,
  output logic [4:0]    depth,
  output logic          stk_err,
  input  logic [DW-1:0] in_port,
  output logic [DW-1:0] out_port
);
  localparam int NREG  = 1 << AW;
  localparam int ENT_W = (SAVE_N + 1) * DW;
  localparam int SPW   = $clog2(STK_DEPTH);
  localparam int CW    = $clog2(STK_DEPTH + 1);

  logic [DW-1:0]    regs  [NREG];
  logic [ENT_W-1:0] stack [STK_DEPTH];
  logic [CW-1:0]    depth_q;
  logic [DW-1:0]    ra_q;
  logic             err_q;

  wire full    = depth_q == CW'(STK_DEPTH);
  wire empty   = depth_q == '0;
  wire push_ok = save & ~load & ~full;
  wire pop_ok  = load & ~save & ~empty;
  wire fault   = (save | load) & ~push_ok & ~pop_ok;

  wire [CW-1:0]    pop_idx = depth_q - CW'(1);
  wire [ENT_W-1:0] popped  = stack[pop_idx[SPW-1:0]];
  logic [ENT_W-1:0] snap;

  for (genvar g = 0; g < SAVE_N; g++) begin : g_snap
    assign snap[g*DW +: DW] = regs[g];
  end
  assign snap[ENT_W-1 -: DW] = ra_q;

  function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
    if (a == AW'(ZERO_IDX))    return '0;
    else if (a == AW'(IN_IDX)) return in_port;
    else                       return regs[a];
  endfunction

  assign rdata1   = rd(addr1);
  assign rdata2   = rd(addr2);
  assign out_port = regs[OUT_IDX];
  assign ret_addr = ra_q;
  assign depth    = 5'(depth_q);
  assign stk_err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (pop_ok && i < SAVE_N)
          regs[i] <= popped[i*DW +: DW];
        else if (cmp_we && i == CMP_IDX)
          regs[i] <= {{(DW-1){1'b0}}, cmp_bit};
        else if (i != IN_IDX && i != ZERO_IDX) begin
          if (we2 && addr2 == AW'(i))      regs[i] <= wdata2;
          else if (we1 && addr1 == AW'(i)) regs[i] <= wdata1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) stack[depth_q[SPW-1:0]] <= snap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
      ra_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= fault;
      if (push_ok)     depth_q <= depth_q + CW'(1);
      else if (pop_ok) depth_q <= pop_idx;
      if (pop_ok)     ra_q <= popped[ENT_W-1 -: DW];
      else if (ra_we) ra_q <= ra_wdata;
    end
  end

  // R12
  full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save && !load && full) |=> (stk_err && depth_q == $past(depth_q)));
  // R12
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !save && empty) |=> (stk_err && depth_q == '0));
  // R8
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save && !load && !full) |=> (depth_q == $past(depth_q) + CW'(1) && !stk_err));
  // R9
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !save && !empty) |=> (depth_q == $past(depth_q) - CW'(1)));
  // R12
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= CW'(STK_DEPTH));
  // R5
  out_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we2 && addr2 == AW'(OUT_IDX) && !load) |=> out_port == $past(wdata2));
endmodule

// File: tb/regfile_callstack_bench.sv
module regfile_callstack_bench;
  logic clk = 0, rst_n = 0;
  logic [5:0] addr1 = 0, addr2 = 0;
  logic [15:0] wdata1 = 0, wdata2 = 0, ra_wdata = 0, in_port = 0;
  logic we1 = 0, we2 = 0, cmp_we = 0, cmp_bit = 0, ra_we = 0, save = 0, load = 0;
  logic [15:0] rdata1, rdata2, ret_addr, out_port;
  logic [4:0] depth;
  logic stk_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  regfile_callstack u_regfile_callstack (.*);

  // {addr[37:32], data[31:16], expected read[15:0]}
  localparam logic [37:0] VEC [8] = '{
    {6'd0,  16'h1111, 16'h1111},
    {6'd14, 16'hAAAA, 16'hAAAA},
    {6'd16, 16'h5A5A, 16'h5A5A},
    {6'd15, 16'h1234, 16'hC0DE},
    {6'd63, 16'hFFFF, 16'h0000},
    {6'd57, 16'h0042, 16'h0042},
    {6'd40, 16'h8001, 16'h8001},
    {6'd62, 16'h7FFF, 16'h7FFF}
  };

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd1(logic [5:0] a, string req, logic [15:0] exp);
    addr1 = a; #1; chk(req, rdata1, exp);
  endtask

  task automatic wr1(logic [5:0] a, logic [15:0] d);
    addr1 = a; wdata1 = d; we1 = 1; step(); we1 = 0;
  endtask

  task automatic fill(logic [15:0] base, logic [15:0] ra);
    for (int i = 0; i < 15; i++) wr1(6'(i), base + 16'(i));
    ra_we = 1; ra_wdata = ra; step(); ra_we = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1; #1;
    // R1
    rd1(6'd5, "R1", 16'h0);
    chk("R1", out_port, 0); chk("R1", depth, 0);
    chk("R1", stk_err, 0); chk("R1", ret_addr, 0);

    // table walk: R2 R4 R5 R6
    in_port = 16'hC0DE;
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) begin
        addr1 = VEC[i][37:32]; wdata1 = VEC[i][31:16]; we1 = 1;
      end else begin
        addr2 = VEC[i][37:32]; wdata2 = VEC[i][31:16]; we2 = 1;
      end
      step(); we1 = 0; we2 = 0;
      addr1 = VEC[i][37:32]; addr2 = VEC[i][37:32]; #1;
      chk("R2/R4/R6 port1", rdata1, VEC[i][15:0]);
      chk("R2/R4/R6 port2", rdata2, VEC[i][15:0]);
      if (VEC[i][37:32] == 6'd16) chk("R5", out_port, 16'h5A5A);
    end
    in_port = 16'h7E57; rd1(6'd15, "R4", 16'h7E57);

    // R3
    addr1 = 30; wdata1 = 16'h0001; we1 = 1;
    addr2 = 30; wdata2 = 16'h0002; we2 = 1;
    step(); we1 = 0; we2 = 0;
    rd1(6'd30, "R3", 16'h0002);

    // R7
    cmp_we = 1; cmp_bit = 1; addr2 = 57; wdata2 = 16'h7777; we2 = 1;
    step(); cmp_we = 0; we2 = 0;
    rd1(6'd57, "R7", 16'h0001);
    cmp_we = 1; cmp_bit = 0; step(); cmp_we = 0;
    rd1(6'd57, "R7", 16'h0000);

    // R13, R8
    fill(16'h0100, 16'h0AB0);
    chk("R13", ret_addr, 16'h0AB0);
    wr1(6'd20, 16'h2020);
    save = 1; step(); save = 0;
    chk("R8", depth, 1); chk("R8", stk_err, 0);
    rd1(6'd3, "R8", 16'h0103);
    chk("R8", ret_addr, 16'h0AB0);

    fill(16'h0F00, 16'h0CCC);
    save = 1; step(); save = 0;
    chk("R11", depth, 2);
    fill(16'h0300, 16'h0DDD);
    wr1(6'd20, 16'h2121);

    // R10: load beats same-cycle writes
    addr1 = 3; wdata1 = 16'hEEEE; we1 = 1; ra_we = 1; ra_wdata = 16'h0999; load = 1;
    step(); load = 0; we1 = 0; ra_we = 0;
    chk("R9", depth, 1);
    chk("R10", ret_addr, 16'h0CCC);
    rd1(6'd3, "R10", 16'h0F03);
    for (int i = 0; i < 15; i++) rd1(6'(i), "R9", 16'h0F00 + 16'(i));
    rd1(6'd20, "R9", 16'h2121);
    chk("R5", out_port, 16'h5A5A);

    load = 1; step(); load = 0;
    chk("R11", depth, 0); chk("R11", ret_addr, 16'h0AB0);
    for (int i = 0; i < 15; i++) rd1(6'(i), "R11", 16'h0100 + 16'(i));

    // R12 underflow
    load = 1; step(); load = 0;
    chk("R12", stk_err, 1); chk("R12", depth, 0);
    rd1(6'd0, "R12", 16'h0100); chk("R12", ret_addr, 16'h0AB0);
    step(); chk("R12", stk_err, 0);

    // R12 overflow with stamped frames
    for (int k = 0; k < 16; k++) begin
      wr1(6'd0, 16'(k));
      save = 1; step(); save = 0;
    end
    chk("R12", depth, 16);
    wr1(6'd0, 16'h0099);
    save = 1; step(); save = 0;
    chk("R12", stk_err, 1); chk("R12", depth, 16);
    load = 1; step(); load = 0;
    chk("R12", depth, 15); rd1(6'd0, "R12", 16'h000F);

    // R12 simultaneous
    save = 1; load = 1; step(); save = 0; load = 0;
    chk("R12", stk_err, 1); chk("R12", depth, 15);
    rd1(6'd0, "R12", 16'h000F);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule